// File: doc/BRIEF.md
# Floating-Point Reservation Station Pool

This block is a small pool of reservation stations in front of one class of floating-point unit. The issue stage presents one operation per cycle along with two source operands. Each source is either a value that is ready now or the tag of the station that will produce it. The pool writes the operation into a free slot and returns that slot's tag, so the rename logic can record it as the producer of the destination register. Each slot has a fixed tag, `TAG_BASE` plus its index; with the defaults the three slots carry tags 1, 2 and 3.

Every slot listens to the shared result bus. When a valid result arrives whose tag matches a source that a slot is waiting for, the slot takes the data in place and marks that source as ready. One result can wake any number of slots. A slot with both sources present asks to dispatch to the functional unit. When several slots are ready, the one issued earliest wins. A slot is dispatched at most once, and it stays occupied until its own tag appears on the result bus.

Top module: `rs_pool`

## Requirements
- R1: While reset is held and on the first cycle after it, every slot is free: `full_o` is 0, `disp_valid_o` is 0 and `iss_tag_o` equals `TAG_BASE`.
- R2: An issue accepted while `full_o` is low goes into the lowest-indexed free slot. `iss_tag_o` shows that slot's tag (`TAG_BASE` plus its index) whenever a slot is free, and shows 0 when the pool is full.
- R3: A source tag of 0 on the issue port means the source value given with it is valid. Any other tag means the value is still pending.
- R4: A result bus cycle with `bc_valid_i` high and a nonzero `bc_tag_i` equal to a pending source tag of an occupied slot stores `bc_data_i` in that source and clears its tag. Every waiting source in every slot that matches is updated in the same cycle.
- R5: If a result with a matching tag arrives in the same cycle that an operation is issued, the new slot stores the data at once and does not wait for that tag.
- R6: A slot asks for dispatch only when both of its source tags are 0. From the cycle after its last source is captured, `disp_valid_o` is high and `disp_op_o`, `disp_vj_o`, `disp_vk_o` and `disp_tag_o` show that slot's contents.
- R7: When several slots are ready, the dispatch port shows the slot that was issued earliest.
- R8: A dispatch takes place in a cycle where `disp_valid_o` and `disp_ready_i` are both high. After a slot has dispatched, it is never shown on the dispatch port again.
- R9: A valid result whose tag equals a slot's own tag frees that slot at the next clock edge, and the slot can be allocated again in the following cycle.
- R10: `full_o` is high exactly when every slot is occupied. An issue while full is ignored and changes no slot.
- R11: A result bus cycle with `bc_valid_i` low, or with a tag of 0, changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | OP_W | Operation code to store |
| iss_vj_i | input | DATA_W | First source value |
| iss_qj_i | input | TAG_W | First source producer tag, 0 if the value is valid |
| iss_vk_i | input | DATA_W | Second source value |
| iss_qk_i | input | TAG_W | Second source producer tag, 0 if the value is valid |
| full_o | output | 1 | No free slot |
| iss_tag_o | output | TAG_W | Tag of the slot the next issue will take, 0 when full |
| bc_valid_i | input | 1 | Result bus valid |
| bc_tag_i | input | TAG_W | Tag of the station producing the result |
| bc_data_i | input | DATA_W | Result value |
| disp_valid_o | output | 1 | A slot is ready to dispatch |
| disp_ready_i | input | 1 | Functional unit accepts the shown slot |
| disp_op_o | output | OP_W | Operation of the shown slot |
| disp_vj_o | output | DATA_W | First operand of the shown slot |
| disp_vk_o | output | DATA_W | Second operand of the shown slot |
| disp_tag_o | output | TAG_W | Tag of the shown slot |

## Verification
A broadcast that is missed or captured into the wrong source shows up in one of two ways. Either a slot never raises `disp_valid_o`, or it dispatches with a stale `disp_vj_o`/`disp_vk_o`, which appears on the cycle after the broadcast. A corrupted age order sends the wrong `disp_tag_o` on the first cycle in which two slots are ready together. A slot that is freed or allocated wrongly shows up at once on `full_o` and `iss_tag_o`. A reference model of the pool is stepped in lock-step with the design and compared on every cycle, so any of these faults is reported within one clock.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned TAG_W  = 4;
  localparam int unsigned OP_W   = 4;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [OP_W-1:0]   op_t;

  typedef struct packed {
    op_t   op;
    data_t vj;
    data_t vk;
    tag_t  qj;
    tag_t  qk;
  } rs_slot_t;

  // replace any source waiting on hit_tag with hit_data
  function automatic rs_slot_t snoop(input rs_slot_t s, input logic hit_v,
                                     input tag_t hit_tag, input data_t hit_data);
    rs_slot_t r;
    r = s;
    if (hit_v && hit_tag != '0) begin
      if (s.qj == hit_tag) begin
        r.vj = hit_data;
        r.qj = '0;
      end
      if (s.qk == hit_tag) begin
        r.vk = hit_data;
        r.qk = '0;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pool_pkg::*;
#(
  parameter int unsigned OWN_TAG = 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     alloc_i,
  input  rs_slot_t slot_i,
  input  logic     bc_valid_i,
  input  tag_t     bc_tag_i,
  input  data_t    bc_data_i,
  input  logic     fire_i,
  output logic     busy_o,
  output logic     req_o,
  output rs_slot_t slot_o
);
  localparam tag_t OwnTag = tag_t'(OWN_TAG);

  logic     busy_q, done_q;
  rs_slot_t slot_q;
  logic     own_hit;

  assign own_hit = bc_valid_i && (bc_tag_i == OwnTag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      slot_q <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      slot_q <= snoop(slot_i, bc_valid_i, bc_tag_i, bc_data_i);
    end else if (busy_q) begin
      slot_q <= snoop(slot_q, bc_valid_i, bc_tag_i, bc_data_i);
      if (fire_i)  done_q <= 1'b1;
      if (own_hit) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign req_o  = busy_q && !done_q && (slot_q.qj == '0) && (slot_q.qk == '0);
  assign slot_o = slot_q;
endmodule

// File: rtl/rs_age_matrix.sv
module rs_age_matrix #(
  parameter int unsigned NUM_ENT = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ENT-1:0] alloc_i,
  input  logic [NUM_ENT-1:0] req_i,
  output logic [NUM_ENT-1:0] grant_o
);
  // older_q[i][j]: slot i was allocated before slot j
  logic [NUM_ENT-1:0][NUM_ENT-1:0] older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else begin
      for (int k = 0; k < NUM_ENT; k++) begin
        if (alloc_i[k]) begin
          for (int j = 0; j < NUM_ENT; j++) begin
            if (j != k) begin
              older_q[k][j] <= 1'b0;
              older_q[j][k] <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      grant_o[i] = req_i[i];
      for (int j = 0; j < NUM_ENT; j++) begin
        grant_o[i] = grant_o[i] && ((j == i) || !req_i[j] || older_q[i][j]);
      end
    end
  end
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pool_pkg::*;
#(
  parameter int unsigned NUM_ENT  = 3,
  parameter int unsigned TAG_BASE = 1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  iss_valid_i,
  input  op_t   iss_op_i,
  input  data_t iss_vj_i,
  input  tag_t  iss_qj_i,
  input  data_t iss_vk_i,
  input  tag_t  iss_qk_i,
  output logic  full_o,
  output tag_t  iss_tag_o,
  input  logic  bc_valid_i,
  input  tag_t  bc_tag_i,
  input  data_t bc_data_i,
  output logic  disp_valid_o,
  input  logic  disp_ready_i,
  output op_t   disp_op_o,
  output data_t disp_vj_o,
  output data_t disp_vk_o,
  output tag_t  disp_tag_o
);
  logic [NUM_ENT-1:0] busy, req, grant, alloc, fire, free_oh;
  rs_slot_t           slots [NUM_ENT];
  rs_slot_t           iss_slot;

  assign iss_slot = '{op: iss_op_i, vj: iss_vj_i, vk: iss_vk_i, qj: iss_qj_i, qk: iss_qk_i};

  // lowest free slot
  always_comb begin
    free_oh   = '0;
    iss_tag_o = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_oh    = '0;
        free_oh[i] = 1'b1;
        iss_tag_o  = tag_t'(TAG_BASE + i);
      end
    end
  end

  assign full_o = &busy;
  assign alloc  = (iss_valid_i && !full_o) ? free_oh : '0;
  assign fire   = disp_ready_i ? grant : '0;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    rs_entry #(.OWN_TAG(TAG_BASE + g)) u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .alloc_i   (alloc[g]),
      .slot_i    (iss_slot),
      .bc_valid_i(bc_valid_i),
      .bc_tag_i  (bc_tag_i),
      .bc_data_i (bc_data_i),
      .fire_i    (fire[g]),
      .busy_o    (busy[g]),
      .req_o     (req[g]),
      .slot_o    (slots[g])
    );
  end

  rs_age_matrix #(.NUM_ENT(NUM_ENT)) u_age (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .alloc_i(alloc),
    .req_i  (req),
    .grant_o(grant)
  );

  assign disp_valid_o = |req;

  always_comb begin
    disp_op_o  = '0;
    disp_vj_o  = '0;
    disp_vk_o  = '0;
    disp_tag_o = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (grant[i]) begin
        disp_op_o  = disp_op_o  | slots[i].op;
        disp_vj_o  = disp_vj_o  | slots[i].vj;
        disp_vk_o  = disp_vk_o  | slots[i].vk;
        disp_tag_o = disp_tag_o | tag_t'(TAG_BASE + i);
      end
    end
  end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk
  import rs_pool_pkg::*;
#(
  parameter int unsigned NUM_ENT  = 3,
  parameter int unsigned TAG_BASE = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               iss_valid_i,
  input logic               full_o,
  input logic               bc_valid_i,
  input tag_t               bc_tag_i,
  input logic               disp_valid_o,
  input logic               disp_ready_i,
  input tag_t               disp_tag_o,
  input logic [NUM_ENT-1:0] busy,
  input logic [NUM_ENT-1:0] grant
);
  a_r7_one_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> $countones(grant) == 1);

  a_r6_tag_in_pool: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> (disp_tag_o >= tag_t'(TAG_BASE)) && (disp_tag_o <= tag_t'(TAG_BASE + NUM_ENT - 1)));

  a_r10_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && iss_valid_i && !bc_valid_i |=> busy == $past(busy));

  a_r2_alloc_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_i && !full_o && !bc_valid_i |=> $countones(busy) == $countones($past(busy)) + 1);

  a_r8_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o && disp_ready_i |=> !(disp_valid_o && disp_tag_o == $past(disp_tag_o)));

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_rel
    a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bc_valid_i && bc_tag_i == tag_t'(TAG_BASE + i) && busy[i] |=> !busy[i]);
  end
endmodule

bind rs_pool rs_pool_chk #(.NUM_ENT(NUM_ENT), .TAG_BASE(TAG_BASE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iss_valid_i (iss_valid_i),
  .full_o      (full_o),
  .bc_valid_i  (bc_valid_i),
  .bc_tag_i    (bc_tag_i),
  .disp_valid_o(disp_valid_o),
  .disp_ready_i(disp_ready_i),
  .disp_tag_o  (disp_tag_o),
  .busy        (busy),
  .grant       (grant)
);

// File: tb/rs_pool_tb.sv
module rs_pool_tb;
  localparam int N    = 3;
  localparam int BASE = 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        iss_valid_i = 1'b0;
  logic [3:0]  iss_op_i = '0;
  logic [63:0] iss_vj_i = '0, iss_vk_i = '0;
  logic [3:0]  iss_qj_i = '0, iss_qk_i = '0;
  logic        full_o;
  logic [3:0]  iss_tag_o;
  logic        bc_valid_i = 1'b0;
  logic [3:0]  bc_tag_i = '0;
  logic [63:0] bc_data_i = '0;
  logic        disp_valid_o;
  logic        disp_ready_i = 1'b0;
  logic [3:0]  disp_op_o;
  logic [63:0] disp_vj_o, disp_vk_o;
  logic [3:0]  disp_tag_o;

  always #5 clk_i = ~clk_i;

  rs_pool u_dut (.*);

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // reference model
  bit          m_busy [N];
  bit          m_done [N];
  logic [3:0]  m_op [N];
  logic [63:0] m_vj [N], m_vk [N];
  logic [3:0]  m_qj [N], m_qk [N];
  int          m_seq [N];
  int          seq_ctr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int m_pick();
    int g = -1;
    for (int i = 0; i < N; i++)
      if (m_busy[i] && !m_done[i] && m_qj[i] == 0 && m_qk[i] == 0 &&
          (g < 0 || m_seq[i] < m_seq[g])) g = i;
    return g;
  endfunction

  function automatic int m_free();
    for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  task automatic compare();
    int g = m_pick();
    int k = m_free();
    chk(full_o == (k < 0), "R10", "full_o", full_o, k < 0);
    chk(iss_tag_o == ((k < 0) ? 4'd0 : 4'(BASE + k)), "R2", "iss_tag_o", iss_tag_o,
        (k < 0) ? 0 : BASE + k);
    chk(disp_valid_o == (g >= 0), "R6", "disp_valid_o", disp_valid_o, g >= 0);
    if (g >= 0 && disp_valid_o) begin
      chk(disp_tag_o == 4'(BASE + g), "R7", "disp_tag_o", disp_tag_o, BASE + g);
      chk(disp_op_o == m_op[g], "R4", "disp_op_o", disp_op_o, m_op[g]);
      chk(disp_vj_o == m_vj[g], "R4", "disp_vj_o", disp_vj_o, m_vj[g]);
      chk(disp_vk_o == m_vk[g], "R4", "disp_vk_o", disp_vk_o, m_vk[g]);
    end
  endtask

  // called at a falling edge; applies one cycle
  task automatic step(input bit iv, input logic [3:0] op, input logic [63:0] vj,
                      input logic [3:0] qj, input logic [63:0] vk, input logic [3:0] qk,
                      input bit bv, input logic [3:0] bt, input logic [63:0] bd, input bit dr);
    int g = m_pick();
    int k = m_free();
    iss_valid_i = iss_valid_i ^ iss_valid_i ^ iv;
    iss_op_i = op; iss_vj_i = vj; iss_qj_i = qj; iss_vk_i = vk; iss_qk_i = qk;
    bc_valid_i = bv; bc_tag_i = bt; bc_data_i = bd; disp_ready_i = dr;
    for (int i = 0; i < N; i++) begin
      if (m_busy[i]) begin
        if (bv && bt != 0 && m_qj[i] == bt) begin m_vj[i] = bd; m_qj[i] = 0; end
        if (bv && bt != 0 && m_qk[i] == bt) begin m_vk[i] = bd; m_qk[i] = 0; end
        if (bv && bt == 4'(BASE + i)) m_busy[i] = 0;
      end
    end
    if (dr && g >= 0) m_done[g] = 1;
    if (iv && k >= 0) begin
      m_busy[k] = 1; m_done[k] = 0; m_op[k] = op;
      m_vj[k] = vj; m_qj[k] = qj; m_vk[k] = vk; m_qk[k] = qk;
      if (bv && bt != 0 && qj == bt) begin m_vj[k] = bd; m_qj[k] = 0; end
      if (bv && bt != 0 && qk == bt) begin m_vk[k] = bd; m_qk[k] = 0; end
      m_seq[k] = seq_ctr++;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
  endtask

  function automatic logic [3:0] rand_q();
    if ($urandom % 2 == 0) return 4'd0;
    case ($urandom % 5)
      0: return 4'd1;
      1: return 4'd2;
      2: return 4'd3;
      3: return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  localparam logic [63:0] A = 64'h1111_0000_0000_000a, B = 64'h2222_0000_0000_000b;
  localparam logic [63:0] C = 64'h3333_0000_0000_000c, D = 64'h4444_0000_0000_000d;
  localparam logic [63:0] E = 64'h5555_0000_0000_000e, F = 64'h6666_0000_0000_000f;

  initial begin
    for (int i = 0; i < N; i++) begin
      m_busy[i] = 0; m_done[i] = 0; m_op[i] = 0; m_vj[i] = 0; m_vk[i] = 0;
      m_qj[i] = 0; m_qk[i] = 0; m_seq[i] = 0;
    end
    repeat (3) @(negedge clk_i);
    chk(!full_o && !disp_valid_o && iss_tag_o == 4'(BASE), "R1", "reset held",
        {full_o, disp_valid_o, iss_tag_o}, {2'b00, 4'(BASE)});
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!full_o && !disp_valid_o && iss_tag_o == 4'(BASE), "R1", "after reset",
        {full_o, disp_valid_o, iss_tag_o}, {2'b00, 4'(BASE)});

    // R3: ready operands dispatch next cycle
    step(1, 4'd1, A, 4'd0, B, 4'd0, 0, 4'd0, 0, 0);
    chk(disp_valid_o && disp_vj_o == A && disp_tag_o == 4'd1, "R3", "ready on issue",
        disp_vj_o, A);
    step(1, 4'd2, 0, 4'd8, C, 4'd0, 0, 4'd0, 0, 0);
    step(1, 4'd3, 0, 4'd8, 0, 4'd8, 0, 4'd0, 0, 0);
    chk(full_o == 1'b1, "R10", "full after three", full_o, 1);
    // R10 issue while full ignored; R11 invalid bus ignored
    step(1, 4'd7, 64'hdead, 4'd0, 64'hbeef, 4'd0, 0, 4'd8, E, 0);
    chk(disp_valid_o && disp_tag_o == 4'd1, "R11", "invalid broadcast ignored",
        disp_tag_o, 1);
    step(0, 0, 0, 0, 0, 0, 1, 4'd0, E, 0);
    chk(disp_tag_o == 4'd1, "R11", "tag zero broadcast ignored", disp_tag_o, 1);
    // R4 one broadcast wakes two slots, R8 slot 1 dispatched
    step(0, 0, 0, 0, 0, 0, 1, 4'd8, D, 1);
    chk(disp_valid_o && disp_tag_o == 4'd2, "R8", "dispatched slot not repeated",
        disp_tag_o, 2);
    step(0, 0, 0, 0, 0, 0, 0, 4'd0, 0, 1);
    chk(disp_tag_o == 4'd3 && disp_vj_o == D && disp_vk_o == D, "R4", "multi wake",
        disp_vk_o, D);
    // R9 own tag frees slot
    step(0, 0, 0, 0, 0, 0, 1, 4'd1, E, 0);
    chk(!full_o && iss_tag_o == 4'd1, "R9", "slot freed", iss_tag_o, 1);
    // R5 same-cycle bypass at issue
    step(1, 4'd5, 0, 4'd10, C, 4'd0, 1, 4'd10, F, 0);
    chk(disp_tag_o == 4'd3, "R7", "oldest first", disp_tag_o, 3);
    step(0, 0, 0, 0, 0, 0, 0, 4'd0, 0, 1);
    chk(disp_valid_o && disp_tag_o == 4'd1 && disp_vj_o == F, "R5", "bypass capture",
        disp_vj_o, F);
    step(0, 0, 0, 0, 0, 0, 1, 4'd2, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1, 4'd3, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 4'd1, 0, 0);
    chk(!full_o && !disp_valid_o && iss_tag_o == 4'd1, "R9", "all freed",
        {disp_valid_o, iss_tag_o}, 1);

    for (int c = 0; c < 4000; c++) begin
      step($urandom % 2 == 0, 4'($urandom), {$urandom, $urandom}, rand_q(),
           {$urandom, $urandom}, rand_q(), $urandom % 3 != 0, 4'($urandom % 12),
           {$urandom, $urandom}, $urandom % 2 == 0);
    end

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_err++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule